// File: doc/BRIEF.md
# Approximate-Second-Minimum Check-Node Unit

This block is the check-node processing stage of a fully parallel low-density parity-check decoder that runs normalized min-sum. It is purely combinational. It takes one sign-magnitude message from each edge attached to a check node. For every edge it returns a message whose sign is the parity of all the other incoming signs. The magnitude of that returned message is a minimum of the other incoming magnitudes, scaled by one half.

To keep the critical path short, only the overall smallest magnitude is found exactly. The edges are grouped into subunits, and each subunit is split into two halves. Each subunit reports its smallest magnitude, the position of that magnitude, and the minimum of its losing half. The second minimum is then approximated from these partial results. All magnitude comparisons read a small computed lookup table instead of using a subtractor. This works because the messages are only a few bits wide. The outputs settle in the same cycle the inputs change.

Top module: `ldpc_cn_pmin`

## Requirements
- R1: Every message is 3 bits wide. Bit 2 is the sign (1 means negative) and bits 1:0 are the magnitude. Edge e sits at bits 3e+2:3e of both the input and the output bus, and there are 8 edges.
- R2: Every edge other than the minimum edge receives the smallest magnitude over all 8 inputs, after scaling.
- R3: The minimum edge is the lowest-numbered edge among those that carry the smallest magnitude.
- R4: Edges 0-3 form subunit 0 and edges 4-7 form subunit 1. Each subunit has a low half (its first two edges) and a high half (its last two edges). The minimum edge receives the scaled minimum of two values: the smallest magnitude in the other subunit, and the smallest magnitude in the half of its own subunit that does not contain it.
- R5: A magnitude that shares a half with the minimum edge is not seen by the approximation. Example: magnitudes 0,1,3,3,3,3,3,3 give edge 0 a magnitude of 1, not the exact-rule 0.
- R6: Scaling by one half rounds down. A magnitude m is output as m shifted right by one bit, so 0 and 1 become 0, and 2 and 3 become 1.
- R7: The output sign of edge e is the XOR of the input signs of all edges except e.
- R8: Input signs have no effect on any output magnitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| v2c_i | input | 24 | Variable-to-check messages, one 3-bit sign-magnitude field per edge |
| c2v_o | output | 24 | Check-to-variable messages, same field layout |

## Verification
Sign exclusion and the second-minimum substitution both act on the minimum edge in the same evaluation. Each needs the other's result to be right for that edge's field to be correct. Tests provoke this case directly. They put a negative sign on the minimum edge, use tied minima across halves and subunits, and use patterns where the approximation differs from the exact rule. Every field of every edge is then judged against a model built from the subunit and half layout in the requirements.

// File: rtl/ldpc_cn_pkg.sv
package ldpc_cn_pkg;
   localparam int LUT_MAX_W = 4;
   localparam int LUT_BITS  = 1 << (2 * LUT_MAX_W);

   typedef logic [LUT_BITS-1:0] lt_lut_t;

   // Bit {a,b} of the table is set when a is strictly smaller than b.
   function automatic lt_lut_t build_lt_lut(input int w);
      lt_lut_t t;
      t = '0;
      for (int a = 0; a < (1 << w); a++)
         for (int b = 0; b < (1 << w); b++)
            t[a * (1 << w) + b] = (a < b);
      return t;
   endfunction
endpackage

// File: rtl/cn_subunit.sv
module cn_subunit
   import ldpc_cn_pkg::*;
#(
   parameter int      MAG_W = 2,
   parameter int      GROUP = 4,
   parameter lt_lut_t LUT   = '0,
   localparam int     IDX_W = (GROUP > 1) ? $clog2(GROUP) : 1,
   localparam int     HALF  = GROUP / 2
) (
   input  logic [GROUP-1:0][MAG_W-1:0] mag_i,
   output logic [MAG_W-1:0]            min_o,
   output logic [IDX_W-1:0]            idx_o,
   output logic [MAG_W-1:0]            comp_o
);
   function automatic logic lt(input logic [MAG_W-1:0] a, input logic [MAG_W-1:0] b);
      return LUT[{a, b}];
   endfunction

   logic [MAG_W-1:0] lo_min, hi_min;
   logic [IDX_W-1:0] lo_idx, hi_idx;

   // Linear scan per half; a strict compare keeps the lowest index on ties.
   always_comb begin
      lo_min = mag_i[0];
      lo_idx = '0;
      for (int j = 1; j < HALF; j++)
         if (lt(mag_i[j], lo_min)) begin
            lo_min = mag_i[j];
            lo_idx = IDX_W'(j);
         end
      hi_min = mag_i[HALF];
      hi_idx = IDX_W'(HALF);
      for (int j = HALF + 1; j < GROUP; j++)
         if (lt(mag_i[j], hi_min)) begin
            hi_min = mag_i[j];
            hi_idx = IDX_W'(j);
         end
   end

   always_comb begin
      if (lt(hi_min, lo_min)) begin
         min_o  = hi_min;
         idx_o  = hi_idx;
         comp_o = lo_min;
      end else begin
         min_o  = lo_min;
         idx_o  = lo_idx;
         comp_o = hi_min;
      end
   end

   always_comb begin
      if (!$isunknown(mag_i)) begin
         for (int j = 0; j < GROUP; j++)
            p_local_min_r2: assert (!lt(mag_i[j], min_o))
               else $error("subunit minimum exceeds member %0d", j);
         p_idx_holds_min_r3: assert (mag_i[idx_o] == min_o)
            else $error("subunit index does not hold the minimum");
         p_comp_ge_min_r4: assert (!lt(comp_o, min_o))
            else $error("competitor below subunit minimum");
      end
   end
endmodule

// File: rtl/cn_combine.sv
module cn_combine
   import ldpc_cn_pkg::*;
#(
   parameter int      MAG_W   = 2,
   parameter int      N_SUB   = 2,
   parameter int      GROUP   = 4,
   parameter lt_lut_t LUT     = '0,
   localparam int     IDX_W   = (GROUP > 1) ? $clog2(GROUP) : 1,
   localparam int     N_EDGES = N_SUB * GROUP,
   localparam int     EIDX_W  = (N_EDGES > 1) ? $clog2(N_EDGES) : 1
) (
   input  logic [N_SUB-1:0][MAG_W-1:0] sub_min_i,
   input  logic [N_SUB-1:0][IDX_W-1:0] sub_idx_i,
   input  logic [N_SUB-1:0][MAG_W-1:0] sub_comp_i,
   output logic [MAG_W-1:0]            first_o,
   output logic [MAG_W-1:0]            second_o,
   output logic [EIDX_W-1:0]           gidx_o
);
   function automatic logic lt(input logic [MAG_W-1:0] a, input logic [MAG_W-1:0] b);
      return LUT[{a, b}];
   endfunction

   int win;

   always_comb begin
      win     = 0;
      first_o = sub_min_i[0];
      for (int s = 1; s < N_SUB; s++)
         if (lt(sub_min_i[s], first_o)) begin
            first_o = sub_min_i[s];
            win     = s;
         end
      second_o = sub_comp_i[win];
      for (int s = 0; s < N_SUB; s++)
         if (s != win && lt(sub_min_i[s], second_o))
            second_o = sub_min_i[s];
      gidx_o = EIDX_W'(win * GROUP + int'(sub_idx_i[win]));
   end

   always_comb begin
      if (!$isunknown(sub_min_i) && !$isunknown(sub_comp_i)) begin
         for (int s = 0; s < N_SUB; s++) begin
            p_first_min_r2: assert (!lt(sub_min_i[s], first_o))
               else $error("global minimum exceeds subunit %0d", s);
            p_tie_low_r3: assert (s >= win || lt(first_o, sub_min_i[s]))
               else $error("lower subunit %0d ties the global minimum", s);
         end
         p_second_ge_first_r4: assert (!lt(second_o, first_o))
            else $error("second minimum below first minimum");
      end
   end
endmodule

// File: rtl/cn_edge_out.sv
module cn_edge_out #(
   parameter int MAG_W    = 2,
   parameter bit ROUND_UP = 1'b0
) (
   input  logic             sign_i,
   input  logic             is_min_i,
   input  logic [MAG_W-1:0] first_i,
   input  logic [MAG_W-1:0] second_i,
   output logic [MAG_W:0]   msg_o
);
   logic [MAG_W-1:0] sel, scaled;

   assign sel = is_min_i ? second_i : first_i;

   generate
      if (ROUND_UP) begin : g_round_up
         logic [MAG_W:0] sum;
         assign sum    = {1'b0, sel} + (MAG_W + 1)'(1);
         assign scaled = sum[MAG_W:1];
      end else begin : g_floor
         assign scaled = sel >> 1;
      end
   endgenerate

   assign msg_o = {sign_i, scaled};

   always_comb begin
      if (!$isunknown(sel))
         p_scale_bound_r6: assert (msg_o[MAG_W-1:0] <= sel)
            else $error("scaled magnitude grew");
   end
endmodule

// File: rtl/ldpc_cn_pmin.sv
module ldpc_cn_pmin
   import ldpc_cn_pkg::*;
#(
   parameter int  N_EDGES  = 8,
   parameter int  N_SUB    = 2,
   parameter int  MAG_W    = 2,
   parameter bit  ROUND_UP = 1'b0,
   localparam int MSG_W    = MAG_W + 1,
   localparam int GROUP    = N_EDGES / N_SUB,
   localparam int IDX_W    = (GROUP > 1) ? $clog2(GROUP) : 1,
   localparam int EIDX_W   = (N_EDGES > 1) ? $clog2(N_EDGES) : 1
) (
   input  logic [N_EDGES*MSG_W-1:0] v2c_i,
   output logic [N_EDGES*MSG_W-1:0] c2v_o
);
   localparam lt_lut_t LUT = build_lt_lut(MAG_W);

   generate
      if (MAG_W < 1 || MAG_W > LUT_MAX_W) begin : g_bad_width
         $error("MAG_W must lie in 1..%0d", LUT_MAX_W);
      end
      if (N_SUB < 1 || (N_EDGES % N_SUB) != 0) begin : g_bad_split
         $error("N_EDGES must divide evenly into N_SUB subunits");
      end
      if (GROUP < 2) begin : g_bad_group
         $error("each subunit needs at least two edges");
      end
   endgenerate

   logic [N_EDGES-1:0][MAG_W-1:0] mag;
   logic [N_EDGES-1:0]            sgn;
   logic                          parity;

   for (genvar e = 0; e < N_EDGES; e++) begin : g_unpack
      assign mag[e] = v2c_i[e*MSG_W +: MAG_W];
      assign sgn[e] = v2c_i[e*MSG_W + MAG_W];
   end
   assign parity = ^sgn;

   logic [N_SUB-1:0][MAG_W-1:0] sub_min, sub_comp;
   logic [N_SUB-1:0][IDX_W-1:0] sub_idx;

   for (genvar s = 0; s < N_SUB; s++) begin : g_sub
      cn_subunit #(.MAG_W(MAG_W), .GROUP(GROUP), .LUT(LUT)) i_sub (
         .mag_i  (mag[s*GROUP +: GROUP]),
         .min_o  (sub_min[s]),
         .idx_o  (sub_idx[s]),
         .comp_o (sub_comp[s])
      );
   end

   logic [MAG_W-1:0]  first, second;
   logic [EIDX_W-1:0] gidx;

   cn_combine #(.MAG_W(MAG_W), .N_SUB(N_SUB), .GROUP(GROUP), .LUT(LUT)) i_comb (
      .sub_min_i  (sub_min),
      .sub_idx_i  (sub_idx),
      .sub_comp_i (sub_comp),
      .first_o    (first),
      .second_o   (second),
      .gidx_o     (gidx)
   );

   for (genvar e = 0; e < N_EDGES; e++) begin : g_edge
      cn_edge_out #(.MAG_W(MAG_W), .ROUND_UP(ROUND_UP)) i_out (
         .sign_i   (parity ^ sgn[e]),
         .is_min_i (gidx == EIDX_W'(e)),
         .first_i  (first),
         .second_i (second),
         .msg_o    (c2v_o[e*MSG_W +: MSG_W])
      );
   end

   logic out_par;
   always_comb begin
      out_par = 1'b0;
      for (int e = 0; e < N_EDGES; e++)
         out_par ^= c2v_o[e*MSG_W + MAG_W];
      if (!$isunknown(v2c_i))
         p_sign_parity_r7: assert (out_par == ((N_EDGES % 2 == 0) ? parity : 1'b0))
            else $error("output sign parity inconsistent with inputs");
   end
endmodule

// File: tb/test_ldpc_cn_pmin.sv
module test_ldpc_cn_pmin;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int G = 4;

   logic        clk = 1'b0;
   logic [23:0] v2c;
   logic [23:0] c2v;
   int          n_chk = 0;
   int          n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ldpc_cn_pmin i_ldpc_cn_pmin (.v2c_i(v2c), .c2v_o(c2v));

   function automatic int magof(logic [23:0] v, int e);
      return int'(v[3*e +: 2]);
   endfunction

   // Model of R2-R7 built from the subunit/half layout.
   function automatic logic [2:0] model(logic [23:0] v, int e);
      int gmin = 3, gidx = 0, sub, half, comp = 3, other = 3, sec, m, par = 0;
      for (int k = 0; k < N; k++) begin
         if (magof(v, k) < gmin) begin gmin = magof(v, k); gidx = k; end
      end
      if (magof(v, 0) == gmin) gidx = 0;
      for (int k = 0; k < N; k++)
         if (magof(v, k) == gmin && k < gidx) gidx = k;
      sub  = gidx / G;
      half = (gidx % G) / 2;
      for (int k = 0; k < N; k++) begin
         if (k / G != sub) begin
            if (magof(v, k) < other) other = magof(v, k);
         end else if ((k % G) / 2 != half) begin
            if (magof(v, k) < comp) comp = magof(v, k);
         end
      end
      sec = (comp < other) ? comp : other;
      m   = (e == gidx) ? sec : gmin;
      for (int k = 0; k < N; k++)
         if (k != e) par ^= int'(v[3*k + 2]);
      return {par[0], 2'(m >> 1)};
   endfunction

   task automatic check_all(input string req);
      logic [2:0] exp;
      for (int e = 0; e < N; e++) begin
         exp = model(v2c, e);
         n_chk++;
         if (c2v[3*e +: 3] !== exp) begin
            n_bad++;
            $display("FAIL %s edge %0d in=%h actual=%b expected=%b",
                     req, e, v2c, c2v[3*e +: 3], exp);
         end
      end
   endtask

   task automatic apply(input logic [23:0] v, input string req);
      @(negedge clk);
      v2c = v;
      @(posedge clk);
      #1;
      check_all(req);
   endtask

   function automatic logic [23:0] pack(int m[8], int s[8]);
      logic [23:0] r;
      for (int k = 0; k < N; k++) r[3*k +: 3] = {s[k][0], 2'(m[k])};
      return r;
   endfunction

   task automatic t_zero();
      apply(24'h0, "R1_zero");
   endtask

   task automatic t_distinct();
      apply(pack('{3,2,3,3,1,3,2,3}, '{0,0,0,0,0,0,0,0}), "R2");
      apply(pack('{3,3,3,3,3,3,3,2}, '{0,0,0,0,0,0,0,0}), "R2");
      apply(pack('{2,3,3,3,3,3,3,3}, '{0,0,0,0,0,0,0,0}), "R6");
   endtask

   task automatic t_ties();
      apply(pack('{3,1,3,1,3,1,3,3}, '{0,0,0,0,0,0,0,0}), "R3");
      apply(pack('{3,3,3,3,0,0,3,3}, '{0,0,0,0,0,0,0,0}), "R3");
      apply(pack('{3,3,0,3,3,3,0,3}, '{1,0,0,0,0,0,0,0}), "R3");
   endtask

   task automatic t_approx();
      apply(pack('{0,1,3,3,3,3,3,3}, '{0,0,0,0,0,0,0,0}), "R5");
      n_chk++;
      if (c2v[1:0] !== 2'd1) begin
         n_bad++;
         $display("FAIL R5 edge 0 actual=%0d expected=1", c2v[1:0]);
      end
      apply(pack('{3,3,2,3,3,0,3,3}, '{0,0,0,0,0,0,0,0}), "R4");
      apply(pack('{3,3,3,3,2,2,0,3}, '{0,0,0,0,0,0,0,0}), "R4");
   endtask

   task automatic t_signs();
      logic [2:0] ref_o[8];
      apply(pack('{2,3,0,3,3,2,3,3}, '{0,0,0,0,0,0,0,0}), "R7");
      for (int e = 0; e < N; e++) ref_o[e] = c2v[3*e +: 3];
      apply(pack('{2,3,0,3,3,2,3,3}, '{1,0,1,1,0,0,1,0}), "R7");
      for (int e = 0; e < N; e++) begin
         n_chk++;
         if (c2v[3*e +: 2] !== ref_o[e][1:0]) begin
            n_bad++;
            $display("FAIL R8 edge %0d actual=%0d expected=%0d",
                     e, c2v[3*e +: 2], ref_o[e][1:0]);
         end
      end
      apply(pack('{1,3,3,3,3,3,3,3}, '{1,1,1,1,1,1,1,1}), "R7");
   endtask

   task automatic t_sweep();
      logic [23:0] lfsr = 24'h5A3C1F;
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
         apply(lfsr, "R4_sweep");
      end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      v2c = '0;
      repeat (2) @(posedge clk);
      t_zero();
      t_distinct();
      t_ties();
      t_approx();
      t_signs();
      t_sweep();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule